// File: doc/BRIEF.md
# Single-Register Interrupt Aggregator

This block gathers a small number of event inputs into one level-type interrupt for a parent controller. Every bit of control and status for the block is held in one 32-bit register. The register is reached over a plain read/write bus that has no address lines. Each source has one enable bit in the low half-word and one sticky pending bit in the high half-word. The pending bit sits exactly 16 positions above its enable bit.

A rising edge on a source input latches its pending bit, whether or not that source is enabled. The parent interrupt is raised while any pending bit has its enable set. Software clears a pending bit by writing 1 to it. Because a 0 written to a pending bit does nothing, software can change the enables in a write that sends zeros to the high half without losing any event. The parameter `NUM_SRC` sets the number of sources, and `SRC_OFS` sets the position of the first enable bit. `SRC_OFS + NUM_SRC` must not exceed 16.

Top module: `evt_irq_agg`

## Requirements
- R1: The enable bits for the sources are register bits [SRC_OFS+NUM_SRC-1:SRC_OFS], which is [6:0] with the defaults. A write loads them, and a read returns them.
- R2: The pending bit of source n is register bit SRC_OFS+n+16. With the defaults this is [22:16]. With NUM_SRC=2 and SRC_OFS=4, the enables are [5:4] and the pending bits are [21:20].
- R3: A 0-to-1 change on src_i[n] sets pending bit n at the next clock edge, whether or not source n is enabled. A source input that stays high does not set its pending bit again after it has been cleared.
- R4: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged.
- R5: When a new rising edge and a write-1 clear reach the same pending bit in the same cycle, the bit ends up set.
- R6: irq_o is a register. One cycle after the pending and enable state changes, irq_o equals the OR over all sources of (pending AND enable).
- R7: irq_o stays high until every enabled pending bit has been cleared. Clearing the enable of a source removes that source from irq_o but keeps its pending bit.
- R8: Register bits outside the enable and pending fields always read as 0, and writes to them have no effect.
- R9: When rst_ni is low, all enable bits, all pending bits and irq_o are cleared.
- R10: A read (req_i=1, we_i=0) returns the register contents on rdata_o after the next clock edge. rdata_o holds that value until the next read. A read issued in the same cycle as a write returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Event inputs; a rising edge latches the pending bit |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Level interrupt to the parent controller |

## Verification
The bench makes an event collide with a clear of the same bit. A design that let the clear win would lose that event. It clears a bit whose input is still held high. A design that latched levels rather than edges would set the bit again at once. It also writes 0 to pending bits while changing the enables, which would destroy events in a design that treated the high half as an ordinary register. The bench then masks a pending source and checks that irq_o drops while the pending bit stays set. It writes all ones to check that the unused bits stay 0. A second instance with a nonzero offset catches field positions that were hard-coded.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int REG_W     = 32;
  localparam int HALF_W    = 16;
  localparam int STS_SHIFT = 16;
endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] en_wdata_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] en_q, sts_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_q[i] <= 1'b0;
      else if (wr_i) en_q[i] <= en_wdata_i[i];
    end

    // new event beats a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 sts_q[i] <= 1'b0;
      else if (set_i[i])           sts_q[i] <= 1'b1;
      else if (wr_i && clr_i[i])   sts_q[i] <= 1'b0;
    end
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((sts_q & $past(set_i)) == $past(set_i)));

  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ((clr_i & ~set_i) != '0)) |=> ((sts_q & $past(clr_i & ~set_i)) == '0));

  assert_no_spurious_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((sts_q & ~$past(sts_q) & ~$past(set_i)) == '0));

  assert_en_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(wr_i)) |-> $stable(en_q));
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int SRC_OFS = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               irq_o
);
  localparam int EN_LO = SRC_OFS;
  localparam int EN_HI = SRC_OFS + NUM_SRC - 1;
  localparam int ST_LO = EN_LO + STS_SHIFT;
  localparam int ST_HI = EN_HI + STS_SHIFT;

  logic               wr, rd;
  logic [NUM_SRC-1:0] rise, en, sts;
  logic [REG_W-1:0]   reg_view, rdata_q;
  logic               irq_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  evt_edge_det #(.W(NUM_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (src_i),
    .rise_o (rise)
  );

  evt_status_bank #(.W(NUM_SRC)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .en_wdata_i (wdata_i[EN_HI:EN_LO]),
    .clr_i      (wdata_i[ST_HI:ST_LO]),
    .set_i      (rise),
    .en_o       (en),
    .sts_o      (sts)
  );

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_comb begin
    reg_view              = '0;
    reg_view[EN_HI:EN_LO] = en;
    reg_view[ST_HI:ST_LO] = sts;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= reg_view;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(sts & en);
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_irq_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (irq_o == |($past(sts) & $past(en))));

  assert_read_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> (rdata_o[ST_HI:ST_LO] == $past(sts) && rdata_o[EN_HI:EN_LO] == $past(en)));

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(rd)) |-> $stable(rdata_o));

  assert_irq_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ((sts & en) != '0)) |=> irq_o);
endmodule

// File: tb/evt_irq_agg_tb.sv
module evt_irq_agg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  src_a = '0;
  logic [1:0]  src_b = '0;
  logic        req_a = 1'b0, req_b = 1'b0, we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  evt_irq_agg u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_a), .req_i(req_a), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_a), .irq_o(irq_a)
  );

  evt_irq_agg #(.NUM_SRC(2), .SRC_OFS(4)) u_dut_ofs (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_b), .req_i(req_b), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_b), .irq_o(irq_b)
  );

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bus(input bit sel_b, input bit wr, input logic [31:0] data);
    we_i = wr; wdata_i = data;
    if (sel_b) req_b = 1'b1; else req_a = 1'b1;
    tick();
    req_a = 1'b0; req_b = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd_check(input bit sel_b, input string req, input logic [31:0] exp);
    bus(sel_b, 1'b0, '0);
    check(req, sel_b ? rdata_b : rdata_a, exp);
  endtask

  task automatic t_reset();
    rd_check(0, "R9 reset reg", 32'h0);
    check("R9 reset irq", {31'b0, irq_a}, 32'h0);
  endtask

  task automatic t_fields();
    bus(0, 1'b1, 32'hFFFF_FFFF);
    rd_check(0, "R1 R8 enable field and unused bits", 32'h0000_007F);
  endtask

  task automatic t_event_mask();
    bus(0, 1'b1, 32'h0);
    src_a = 7'h04; tick();
    rd_check(0, "R3 R2 event sets status while disabled", 32'h0004_0000);
    check("R6 no irq while disabled", {31'b0, irq_a}, 32'h0);
    bus(0, 1'b1, 32'h0000_0004); tick();
    check("R6 irq after enable", {31'b0, irq_a}, 32'h1);
    bus(0, 1'b1, 32'h0); tick();
    check("R7 mask drops irq", {31'b0, irq_a}, 32'h0);
    rd_check(0, "R7 mask keeps status", 32'h0004_0000);
    bus(0, 1'b1, 32'h0000_0004); tick();
    check("R7 irq held while pending", {31'b0, irq_a}, 32'h1);
    repeat (3) tick();
    bus(0, 1'b1, 32'h0004_0004);
    rd_check(0, "R3 R4 clear with level held high", 32'h0000_0004);
    check("R6 irq after clear", {31'b0, irq_a}, 32'h0);
  endtask

  task automatic t_write_zero();
    src_a = 7'h24; tick();
    rd_check(0, "R3 second event", 32'h0020_0004);
    bus(0, 1'b1, 32'h0000_0004);
    rd_check(0, "R4 write 0 keeps status", 32'h0020_0004);
  endtask

  task automatic t_collision();
    src_a = 7'h00; tick();
    src_a = 7'h02; tick();
    src_a = 7'h00; tick();
    src_a = 7'h02;
    bus(0, 1'b1, 32'h0002_0004);
    rd_check(0, "R5 event beats clear", 32'h0022_0004);
  endtask

  task automatic t_multi();
    bus(0, 1'b1, 32'h0000_007F);
    check("R10 rdata holds without read", rdata_a, 32'h0022_0004);
    rd_check(0, "R10 read returns new enables", 32'h0022_007F);
    bus(0, 1'b1, 32'h0020_007F); tick();
    check("R7 irq stays with one pending", {31'b0, irq_a}, 32'h1);
    bus(0, 1'b1, 32'h0002_007F);
    rd_check(0, "R4 all cleared", 32'h0000_007F);
    check("R7 irq drops after last clear", {31'b0, irq_a}, 32'h0);
  endtask

  task automatic t_offset();
    bus(1, 1'b1, 32'hFFFF_FFFF);
    rd_check(1, "R2 R8 offset enable field", 32'h0000_0030);
    src_b = 2'b01; tick();
    rd_check(1, "R2 offset status bit 20", 32'h0010_0030);
    check("R6 offset irq", {31'b0, irq_b}, 32'h1);
    bus(1, 1'b1, 32'h0010_0000);
    rd_check(1, "R4 R2 offset clear", 32'h0000_0000);
  endtask

  task automatic t_midreset();
    src_a = 7'h00; tick();
    src_a = 7'h08; tick(); tick();
    check("R9 pre-reset irq", {31'b0, irq_a}, 32'h1);
    src_a = 7'h00;
    rst_ni = 1'b0; tick(); rst_ni = 1'b1;
    check("R9 reset clears irq", {31'b0, irq_a}, 32'h0);
    rd_check(0, "R9 reset clears reg", 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_fields();
    t_event_mask();
    t_write_zero();
    t_collision();
    t_multi();
    t_offset();
    t_midreset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule